// File: doc/BRIEF.md
# CAN Receive Buffer Allocator

This block sits behind a CAN protocol engine and picks the message buffer that receives a finished frame. The engine presents the received identifier, the IDE and RTR bits, the length code and eight data bytes. It raises a one-cycle commit strobe once the frame has stayed error-free through the sixth end-of-frame bit. In that same cycle the block tests the frame against the acceptance filter of each of the sixteen buffers. It keeps only buffers whose enable bit is set in that cycle and gives the frame to the lowest-numbered survivor. All fields are written into that buffer in one clock.

Per buffer, a register block outside this design supplies the programmed identifier, the expected IDE value, an enable bit, a receive interrupt enable and a two-bit mask selector. Two mask registers are shared by all buffers. The block holds the stored frames, a receive-complete flag and an overrun flag per buffer, and a pointer to the last buffer written. It drives one interrupt request. A halt input freezes reception so that identifiers and masks can be changed safely. An enable bit cleared in the commit cycle removes that buffer from the choice as a whole. The frame then goes to the next passing buffer, or nowhere, and never to buffer 0 by default.

Top module: `canrx_slot_alloc`

## Requirements
- R1: After reset every receive-complete flag, overrun flag and stored field is 0, the last-event pointer is 0 and the interrupt request is low.
- R2: A buffer passes only if the frame IDE equals the buffer's IDE setting and the identifier bits under care match the programmed identifier. Selector 2'b00 or 2'b11 cares about every bit, 2'b01 uses mask A and 2'b10 uses mask B, and a mask bit of 1 means "don't care". For a standard frame (IDE=0) only identifier bits [10:0] are compared, and the programmed and received identifiers sit in bits [10:0].
- R3: On a commit, the frame goes to the lowest-indexed buffer that passes the filter and is enabled. Its identifier, IDE, RTR, length code and data appear on that buffer's outputs one cycle after the commit.
- R4: Enable bits are sampled in the commit cycle itself. A buffer whose enable is 0 in that cycle never receives the frame, the frame goes to the next passing enabled buffer, and a disabled buffer 0 is never written.
- R5: A commit that no enabled buffer passes stores nothing and changes no flag and no pointer.
- R6: One cycle after a store into buffer k, the last-event pointer reads k and receive-complete flag k is 1.
- R7: A store into a buffer whose receive-complete flag is already 1 sets that buffer's overrun flag.
- R8: While halt is 1, commits are ignored.
- R9: The interrupt request is 1 exactly when some buffer has both its receive-complete flag and its interrupt enable set.
- R10: A pulse on bit k of the receive-complete or overrun clear input clears that flag one cycle later. A store into buffer k in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| halt_i | input | 1 | Suspends frame commits |
| rx_commit_i | input | 1 | One-cycle strobe: received frame is complete and error-free |
| rx_id_i | input | 29 | Received identifier (standard ID in bits [10:0]) |
| rx_ide_i | input | 1 | Received IDE bit |
| rx_rtr_i | input | 1 | Received RTR bit |
| rx_dlc_i | input | 4 | Received length code |
| rx_data_i | input | 64 | Received data bytes |
| buf_valid_i | input | 16 | Per-buffer enable |
| buf_rie_i | input | 16 | Per-buffer receive interrupt enable |
| buf_ide_i | input | 16 | Per-buffer expected IDE |
| buf_msel_i | input | 32 | Per-buffer mask selector, 2 bits each, buffer k at [2k+1:2k] |
| buf_id_i | input | 464 | Per-buffer programmed identifier, buffer k at [29k+28:29k] |
| mask_a_i | input | 29 | Shared acceptance mask A (1 = don't care) |
| mask_b_i | input | 29 | Shared acceptance mask B (1 = don't care) |
| rc_clr_i | input | 16 | Receive-complete clear pulses |
| ovr_clr_i | input | 16 | Overrun clear pulses |
| st_id_o | output | 464 | Stored identifiers, buffer k at [29k+28:29k] |
| st_ide_o | output | 16 | Stored IDE bits |
| st_rtr_o | output | 16 | Stored RTR bits |
| st_dlc_o | output | 64 | Stored length codes, buffer k at [4k+3:4k] |
| st_data_o | output | 1024 | Stored data, buffer k at [64k+63:64k] |
| rc_flag_o | output | 16 | Receive-complete flags |
| ovr_flag_o | output | 16 | Overrun flags |
| last_ptr_o | output | 4 | Index of the last buffer written |
| irq_o | output | 1 | Receive interrupt request |

## Verification
The commit path contains only one register stage, so any wrong choice shows at the ports one cycle after the strobe. It appears as a pointer naming the wrong buffer, a receive-complete flag rising on the wrong bit, or another buffer's contents changing. A wrongly kept enable or a default-to-zero fault shows on buffer 0's stored identifier and on the pointer falling to 0 in that same cycle. Overrun and clear-ordering faults only show on the next store into the same buffer, so the stimulus revisits buffers whose flags are still set.

// File: rtl/canrx_pkg.sv
package canrx_pkg;

    localparam int CANRX_NBUF   = 16;
    localparam int CANRX_ID_W   = 29;
    localparam int CANRX_STD_W  = 11;
    localparam int CANRX_DLC_W  = 4;
    localparam int CANRX_DATA_W = 64;
    localparam int CANRX_MSEL_W = 2;

    // Mask selector encoding
    typedef enum logic [CANRX_MSEL_W-1:0] {
        MS_EXACT     = 2'b00,
        MS_GRP_A     = 2'b01,
        MS_GRP_B     = 2'b10,
        MS_EXACT_ALT = 2'b11
    } msel_e;

    // One stored frame
    typedef struct packed {
        logic [CANRX_ID_W-1:0]   id;
        logic                    ide;
        logic                    rtr;
        logic [CANRX_DLC_W-1:0]  dlc;
        logic [CANRX_DATA_W-1:0] data;
    } entry_t;

endpackage

// File: rtl/canrx_accept.sv
module canrx_accept
    import canrx_pkg::*;
(
    input  logic [CANRX_ID_W-1:0]   buf_id,
    input  logic                    buf_ide,
    input  logic [CANRX_MSEL_W-1:0] msel,
    input  logic [CANRX_ID_W-1:0]   mask_a,
    input  logic [CANRX_ID_W-1:0]   mask_b,
    input  logic [CANRX_ID_W-1:0]   rx_id,
    input  logic                    rx_ide,
    output logic                    pass
);

    logic [CANRX_ID_W-1:0] care;

    always_comb begin
        unique case (msel_e'(msel))
            MS_GRP_A: care = ~mask_a;
            MS_GRP_B: care = ~mask_b;
            default:  care = '1;
        endcase
        if (!rx_ide) begin
            care[CANRX_ID_W-1:CANRX_STD_W] = '0;
        end
        pass = (rx_ide == buf_ide) && (((rx_id ^ buf_id) & care) == '0);
    end

endmodule

// File: rtl/canrx_pick.sv
module canrx_pick #(
    parameter  int N  = 16,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  grant,
    output logic [IW-1:0] idx,
    output logic          any
);

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IW'(i);
            end
        end
        any   = |req;
        grant = '0;
        if (any) begin
            grant[idx] = 1'b1;
        end
    end

endmodule

// File: rtl/canrx_store.sv
module canrx_store
    import canrx_pkg::*;
#(
    parameter  int N  = 16,
    localparam int IW = $clog2(N)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [IW-1:0]        widx,
    input  entry_t               frame,
    input  logic [N-1:0]         rc_clr,
    input  logic [N-1:0]         ovr_clr,
    output entry_t [N-1:0]       ents,
    output logic   [N-1:0]       rc,
    output logic   [N-1:0]       ovr,
    output logic   [IW-1:0]      last
);

    typedef struct packed {
        entry_t [N-1:0] ent;
        logic   [N-1:0] rc;
        logic   [N-1:0] ovr;
        logic   [IW-1:0] last;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.rc  = st_q.rc & ~rc_clr;
        st_d.ovr = st_q.ovr & ~ovr_clr;
        if (we) begin
            st_d.ent[widx] = frame;
            st_d.ovr[widx] = st_q.ovr[widx] | st_q.rc[widx];
            st_d.rc[widx]  = 1'b1;
            st_d.last      = widx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ents = st_q.ent;
    assign rc   = st_q.rc;
    assign ovr  = st_q.ovr;
    assign last = st_q.last;

    // R6: pointer and flag follow the written buffer
    p_last_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (st_q.last == $past(widx)) && st_q.rc[$past(widx)]);

    // R7: store on a pending flag raises overrun
    p_overrun_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (we && st_q.rc[widx]) |=> st_q.ovr[$past(widx)]);

    // R10: without a store, cleared flags read 0
    p_clear_takes_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> ((st_q.rc & $past(rc_clr)) == '0) && ((st_q.ovr & $past(ovr_clr)) == '0));

    // R10: store beats a same-cycle clear
    p_store_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (we && rc_clr[widx]) |=> st_q.rc[$past(widx)]);

endmodule

// File: rtl/canrx_slot_alloc.sv
module canrx_slot_alloc
    import canrx_pkg::*;
#(
    parameter  int NBUF  = CANRX_NBUF,
    localparam int IDX_W = $clog2(NBUF)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          halt_i,
    input  logic                          rx_commit_i,
    input  logic [CANRX_ID_W-1:0]         rx_id_i,
    input  logic                          rx_ide_i,
    input  logic                          rx_rtr_i,
    input  logic [CANRX_DLC_W-1:0]        rx_dlc_i,
    input  logic [CANRX_DATA_W-1:0]       rx_data_i,
    input  logic [NBUF-1:0]               buf_valid_i,
    input  logic [NBUF-1:0]               buf_rie_i,
    input  logic [NBUF-1:0]               buf_ide_i,
    input  logic [NBUF*CANRX_MSEL_W-1:0]  buf_msel_i,
    input  logic [NBUF*CANRX_ID_W-1:0]    buf_id_i,
    input  logic [CANRX_ID_W-1:0]         mask_a_i,
    input  logic [CANRX_ID_W-1:0]         mask_b_i,
    input  logic [NBUF-1:0]               rc_clr_i,
    input  logic [NBUF-1:0]               ovr_clr_i,
    output logic [NBUF*CANRX_ID_W-1:0]    st_id_o,
    output logic [NBUF-1:0]               st_ide_o,
    output logic [NBUF-1:0]               st_rtr_o,
    output logic [NBUF*CANRX_DLC_W-1:0]   st_dlc_o,
    output logic [NBUF*CANRX_DATA_W-1:0]  st_data_o,
    output logic [NBUF-1:0]               rc_flag_o,
    output logic [NBUF-1:0]               ovr_flag_o,
    output logic [IDX_W-1:0]              last_ptr_o,
    output logic                          irq_o
);

    logic [NBUF-1:0]  pass;
    logic [NBUF-1:0]  elig;
    logic [NBUF-1:0]  grant;
    logic [IDX_W-1:0] pick_idx;
    logic             pick_any;
    entry_t           frame;
    entry_t [NBUF-1:0] ents;

    // Acceptance filters, one per buffer
    for (genvar g = 0; g < NBUF; g++) begin : g_acc
        canrx_accept u_acc (
            .buf_id  (buf_id_i[g*CANRX_ID_W +: CANRX_ID_W]),
            .buf_ide (buf_ide_i[g]),
            .msel    (buf_msel_i[g*CANRX_MSEL_W +: CANRX_MSEL_W]),
            .mask_a  (mask_a_i),
            .mask_b  (mask_b_i),
            .rx_id   (rx_id_i),
            .rx_ide  (rx_ide_i),
            .pass    (pass[g])
        );
    end

    // Enable bits taken in the commit cycle itself
    assign elig = pass & buf_valid_i & {NBUF{rx_commit_i & ~halt_i}};

    canrx_pick #(.N(NBUF)) u_pick (
        .req   (elig),
        .grant (grant),
        .idx   (pick_idx),
        .any   (pick_any)
    );

    assign frame = '{id: rx_id_i, ide: rx_ide_i, rtr: rx_rtr_i,
                     dlc: rx_dlc_i, data: rx_data_i};

    canrx_store #(.N(NBUF)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (pick_any),
        .widx    (pick_idx),
        .frame   (frame),
        .rc_clr  (rc_clr_i),
        .ovr_clr (ovr_clr_i),
        .ents    (ents),
        .rc      (rc_flag_o),
        .ovr     (ovr_flag_o),
        .last    (last_ptr_o)
    );

    for (genvar g = 0; g < NBUF; g++) begin : g_flat
        assign st_id_o[g*CANRX_ID_W +: CANRX_ID_W]       = ents[g].id;
        assign st_ide_o[g]                               = ents[g].ide;
        assign st_rtr_o[g]                               = ents[g].rtr;
        assign st_dlc_o[g*CANRX_DLC_W +: CANRX_DLC_W]    = ents[g].dlc;
        assign st_data_o[g*CANRX_DATA_W +: CANRX_DATA_W] = ents[g].data;
    end

    assign irq_o = |(rc_flag_o & buf_rie_i);

    // R3: chosen buffer is eligible and no lower one is
    p_lowest_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pick_any |-> elig[pick_idx] &&
        ((elig & (({{(NBUF-1){1'b0}}, 1'b1} << pick_idx) - 1'b1)) == '0));

    // R4: a disabled buffer is never granted
    p_disabled_skipped_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~buf_valid_i) == '0);

    // R5: commit without a hit leaves flags and pointer alone
    p_miss_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_commit_i && !halt_i && elig == '0 && rc_clr_i == '0 && ovr_clr_i == '0)
        |=> $stable(rc_flag_o) && $stable(ovr_flag_o) && $stable(last_ptr_o));

    // R8: halted commits change nothing
    p_halt_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_i && rc_clr_i == '0 && ovr_clr_i == '0)
        |=> $stable(rc_flag_o) && $stable(ovr_flag_o) && $stable(last_ptr_o));

endmodule

// File: tb/sim_canrx_slot_alloc.sv
module sim_canrx_slot_alloc;

    localparam int NB = 16;
    localparam int IW = 29;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic            halt = 1'b0;
    logic            commit = 1'b0;
    logic [IW-1:0]   rx_id = '0;
    logic            rx_ide = 1'b0, rx_rtr = 1'b0;
    logic [3:0]      rx_dlc = '0;
    logic [63:0]     rx_data = '0;
    logic [NB-1:0]   cfg_valid = '0, cfg_rie = '0, cfg_ide = '0;
    logic [1:0]      cfg_msel [NB];
    logic [IW-1:0]   cfg_id [NB];
    logic [IW-1:0]   mask_a = '0, mask_b = '0;
    logic [NB-1:0]   rc_clr = '0, ovr_clr = '0;
    logic [NB*2-1:0]  msel_v;
    logic [NB*IW-1:0] id_v;

    always_comb begin
        for (int k = 0; k < NB; k++) begin
            msel_v[k*2 +: 2]  = cfg_msel[k];
            id_v[k*IW +: IW]  = cfg_id[k];
        end
    end

    logic [NB*IW-1:0] st_id;
    logic [NB-1:0]    st_ide, st_rtr, rc_f, ovr_f;
    logic [NB*4-1:0]  st_dlc;
    logic [NB*64-1:0] st_data;
    logic [3:0]       last_ptr;
    logic             irq;

    canrx_slot_alloc u0 (
        .clk(clk), .rst_n(rst_n), .halt_i(halt), .rx_commit_i(commit),
        .rx_id_i(rx_id), .rx_ide_i(rx_ide), .rx_rtr_i(rx_rtr),
        .rx_dlc_i(rx_dlc), .rx_data_i(rx_data),
        .buf_valid_i(cfg_valid), .buf_rie_i(cfg_rie), .buf_ide_i(cfg_ide),
        .buf_msel_i(msel_v), .buf_id_i(id_v),
        .mask_a_i(mask_a), .mask_b_i(mask_b),
        .rc_clr_i(rc_clr), .ovr_clr_i(ovr_clr),
        .st_id_o(st_id), .st_ide_o(st_ide), .st_rtr_o(st_rtr),
        .st_dlc_o(st_dlc), .st_data_o(st_data),
        .rc_flag_o(rc_f), .ovr_flag_o(ovr_f),
        .last_ptr_o(last_ptr), .irq_o(irq)
    );

    // Reference state built from the requirements
    logic [NB-1:0] m_rc = '0, m_ovr = '0;
    logic [3:0]    m_last = '0;
    logic [IW-1:0] m_id [NB];
    logic          m_ide [NB];
    logic          m_rtr [NB];
    logic [3:0]    m_dlc [NB];
    logic [63:0]   m_data [NB];

    typedef struct {
        int            due;
        logic [NB-1:0] rc;
        logic [NB-1:0] ovr;
        logic [3:0]    last;
        logic          irq;
        int            idx;
        logic [IW-1:0] id;
        logic          ide;
        logic          rtr;
        logic [3:0]    dlc;
        logic [63:0]   data;
        string         req;
    } item_t;

    item_t q[$];
    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    // R2 acceptance rule
    function automatic bit ref_pass(int k, logic [IW-1:0] id, logic ide);
        logic [IW-1:0] care;
        case (cfg_msel[k])
            2'b01:   care = ~mask_a;
            2'b10:   care = ~mask_b;
            default: care = '1;
        endcase
        if (!ide) care[IW-1:11] = '0;
        return (ide == cfg_ide[k]) && (((id ^ cfg_id[k]) & care) == '0);
    endfunction

    task automatic push_item(input int idx, input string req);
        item_t it;
        it.due  = cyc + 2;
        it.rc   = m_rc;
        it.ovr  = m_ovr;
        it.last = m_last;
        it.irq  = |(m_rc & cfg_rie);
        it.idx  = idx;
        it.id   = m_id[idx];
        it.ide  = m_ide[idx];
        it.rtr  = m_rtr[idx];
        it.dlc  = m_dlc[idx];
        it.data = m_data[idx];
        it.req  = req;
        q.push_back(it);
    endtask

    // Driver: one commit with optional same-cycle enable and flag clears
    task automatic send(input logic [IW-1:0] id, input logic ide, input logic rtr,
                        input logic [3:0] dlc, input logic [63:0] data,
                        input logic [NB-1:0] vclr, input logic [NB-1:0] rcclr,
                        input int watch, input string req);
        logic [NB-1:0] old_rc, old_ovr;
        int tgt;
        @(posedge clk); #2;
        rx_id = id; rx_ide = ide; rx_rtr = rtr; rx_dlc = dlc; rx_data = data;
        cfg_valid = cfg_valid & ~vclr;
        rc_clr = rcclr;
        commit = 1'b1;
        old_rc = m_rc; old_ovr = m_ovr;
        m_rc = m_rc & ~rcclr;
        tgt = -1;
        if (!halt) begin
            for (int k = NB - 1; k >= 0; k--) begin
                if (cfg_valid[k] && ref_pass(k, id, ide)) tgt = k;
            end
        end
        if (tgt >= 0) begin
            m_ovr[tgt] = old_ovr[tgt] | old_rc[tgt];
            m_rc[tgt]  = 1'b1;
            m_last     = tgt[3:0];
            m_id[tgt] = id; m_ide[tgt] = ide; m_rtr[tgt] = rtr;
            m_dlc[tgt] = dlc; m_data[tgt] = data;
        end
        push_item((tgt >= 0) ? tgt : watch, req);
        @(posedge clk); #2;
        commit = 1'b0;
        rc_clr = '0;
    endtask

    task automatic clear(input logic [NB-1:0] rcm, input logic [NB-1:0] ovm,
                         input string req);
        @(posedge clk); #2;
        rc_clr = rcm; ovr_clr = ovm;
        m_rc = m_rc & ~rcm;
        m_ovr = m_ovr & ~ovm;
        push_item(int'(m_last), req);
        @(posedge clk); #2;
        rc_clr = '0; ovr_clr = '0;
    endtask

    // Monitor: compare ports against queued expectations
    always @(negedge clk) begin
        item_t it;
        cyc++;
        while (q.size() > 0 && q[0].due == cyc) begin
            it = q.pop_front();
            chk(rc_f == it.rc, it.req, "rc_flag", 64'(rc_f), 64'(it.rc));
            chk(ovr_f == it.ovr, it.req, "ovr_flag", 64'(ovr_f), 64'(it.ovr));
            chk(last_ptr == it.last, it.req, "last_ptr", 64'(last_ptr), 64'(it.last));
            chk(irq == it.irq, it.req, "irq", 64'(irq), 64'(it.irq));
            chk(st_id[it.idx*IW +: IW] == it.id, it.req, "st_id",
                64'(st_id[it.idx*IW +: IW]), 64'(it.id));
            chk({st_ide[it.idx], st_rtr[it.idx], st_dlc[it.idx*4 +: 4]} ==
                {it.ide, it.rtr, it.dlc}, it.req, "ide_rtr_dlc",
                64'({st_ide[it.idx], st_rtr[it.idx], st_dlc[it.idx*4 +: 4]}),
                64'({it.ide, it.rtr, it.dlc}));
            chk(st_data[it.idx*64 +: 64] == it.data, it.req, "st_data",
                st_data[it.idx*64 +: 64], it.data);
        end
    end

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog act=%0d exp=0", q.size());
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int k = 0; k < NB; k++) begin
            cfg_msel[k] = 2'b00;
            cfg_id[k]   = 29'(11'h100 + k);
            m_id[k] = '0; m_ide[k] = 1'b0; m_rtr[k] = 1'b0;
            m_dlc[k] = '0; m_data[k] = '0;
        end
        cfg_id[0] = 29'h7F0;
        cfg_valid = 16'hFFFE;
        cfg_rie   = 16'h0024;
        // buffers 8/9: same ID, mask A vs exact
        cfg_id[8] = 29'h200; cfg_msel[8] = 2'b01; mask_a = 29'h00F;
        cfg_id[9] = 29'h200;
        // buffer 10: extended, mask B
        cfg_id[10] = 29'h1ABCDE00; cfg_ide[10] = 1'b1; cfg_msel[10] = 2'b10;
        mask_b = 29'h0FF;
        cfg_id[11] = 29'h300; cfg_id[12] = 29'h300;
        cfg_id[13] = 29'h3F0; cfg_id[14] = 29'h3F0; cfg_msel[14] = 2'b11;

        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(rc_f == '0, "R1", "rc_flag", 64'(rc_f), 0);
        chk(ovr_f == '0, "R1", "ovr_flag", 64'(ovr_f), 0);
        chk(last_ptr == '0, "R1", "last_ptr", 64'(last_ptr), 0);
        chk(irq == 1'b0, "R1", "irq", 64'(irq), 0);
        chk(st_id == '0 && st_data == '0, "R1", "stored", 64'(st_id[63:0]), 0);

        // R3 R6 R9: simple hit, irq enabled buffer
        send(29'h105, 0, 0, 4'd8, 64'h0123456789ABCDEF, '0, '0, 0, "R3_R6_R9");
        send(29'h101, 0, 1, 4'd0, 64'h0, '0, '0, 0, "R3_R6");
        // R2 mask A accepts, exact buffer 9 loses priority/filter
        send(29'h20A, 0, 0, 4'd2, 64'hAAAA, '0, '0, 9, "R2_maskA");
        // R3 R7: both 8 and 9 pass, 8 wins, overrun on 8
        send(29'h200, 0, 0, 4'd3, 64'hBBBB, '0, '0, 9, "R3_R7");
        // R2 mask B on extended frame
        send(29'h1ABCDE55, 1, 0, 4'd7, 64'hCAFEF00D, '0, '0, 0, "R2_maskB");
        // R2 R5: IDE mismatch, no hit anywhere
        send(29'h255, 0, 0, 4'd1, 64'h1, '0, '0, 10, "R2_R5_miss");
        // R2: upper bits ignored on standard frame, R7 overrun on 5
        send(29'h1F000105, 0, 0, 4'd4, 64'h5555, '0, '0, 0, "R2_std_R7");
        // R4: buffer 11 disabled in commit cycle, frame goes to 12
        send(29'h300, 0, 0, 4'd5, 64'h3030, 16'h0800, '0, 0, "R4_next");
        // R4 R5: all passing buffers disabled, buffer 0 untouched
        send(29'h300, 0, 0, 4'd6, 64'h3131, 16'h1000, '0, 0, "R4_none");
        // R2 selector 2'b11 exact: 13 wins, then 14 after disabling 13
        send(29'h3F0, 0, 0, 4'd1, 64'h13, '0, '0, 0, "R3_prio13");
        send(29'h3F0, 0, 0, 4'd1, 64'h14, 16'h2000, '0, 0, "R4_prio14");
        send(29'h3F1, 0, 0, 4'd1, 64'h15, '0, '0, 14, "R2_exact11");
        // R8 halt
        halt = 1'b1;
        send(29'h101, 0, 0, 4'd2, 64'hDEAD, '0, '0, 1, "R8_halt");
        halt = 1'b0;
        // R10 clears and R9 interrupt drop
        clear(16'h0020, 16'h0020, "R10_clear");
        clear(16'h0004, 16'h0000, "R9_irq");
        send(29'h105, 0, 0, 4'd1, 64'h77, '0, '0, 0, "R9_rc5");
        send(29'h105, 0, 0, 4'd2, 64'h78, '0, 16'h0020, 0, "R10_store_wins");
        send(29'h102, 0, 0, 4'd8, 64'hFFFFFFFFFFFFFFFF, '0, '0, 0, "R9_irq2");

        wait (q.size() == 0);
        repeat (2) @(posedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule